// File: doc/BRIEF.md
# Pin Command Streamer with Capture Return

The block sits between a command producer and a set of device pins. Each command names the levels to drive, which pins to drive, a capture request bit and a tag word. An accepted command goes into a registered pin stage. The stage has a fixed depth: 1 models plain single-rate flops and 2 models double-rate buffers. When a command asks for a capture, the pin levels present at its accept edge are returned on a separate sample stream, together with that command's tag.

The sample stream uses valid/ready flow control. The consumer's ready gates command acceptance combinationally, whatever the capture bit is. Captures already inside the pin stage when the consumer stalls drop into a skid store as deep as the stage. While that store holds anything, no new command is taken, so no capture is ever lost or reordered.

Top module: `pin_streamer`

## Requirements
- R1: A command accepted with `cmd_sample` = 0 changes only the pins. It never produces a transfer on the sample stream.
- R2: `pin_o`/`pin_oe` take the values of an accepted command LATENCY clock edges after its accept edge, counting the accept edge, and hold them until a later command arrives.
- R3: `cmd_ready` is high only while `smp_ready` is high. The value of `cmd_sample` has no effect on it.
- R4: The returned `smp_data` is the value of `pin_i` at the clock edge that accepts the requesting command, before that command's outputs appear.
- R5: With the consumer ready, a requested sample is presented LATENCY edges after the accept edge and carries the requesting command's `cmd_meta` on `smp_meta`.
- R6: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data`/`smp_meta` stay unchanged on the next cycle.
- R7: Every requested sample is delivered exactly once and in request order under any stall pattern. This includes two sampling commands on consecutive cycles followed by a one-cycle drop of `smp_ready`.
- R8: The skid store holds up to LATENCY entries. While it holds any entry, `cmd_ready` stays low even if `smp_ready` is high.
- R9: After reset, `pin_o` and `pin_oe` are 0, `smp_valid` is 0, the skid store is empty and `cmd_ready` follows `smp_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken at this edge |
| cmd_out | input | WIDTH | Levels to drive |
| cmd_oe | input | WIDTH | Per-pin drive enables |
| cmd_sample | input | 1 | Capture request |
| cmd_meta | input | META_W | Tag returned with the capture |
| pin_i | input | WIDTH | Pin levels seen from the device |
| pin_o | output | WIDTH | Driven pin levels |
| pin_oe | output | WIDTH | Driven pin enables |
| smp_valid | output | 1 | Captured sample offered |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_data | output | WIDTH | Captured pin levels |
| smp_meta | output | META_W | Tag of the requesting command |

## Verification
The bench builds the block with WIDTH 4, META_W 6 and LATENCY 2 by default. LATENCY 2 is the depth at which two captures can be in flight at once and the skid store fills to its limit. The bench parameter LAT can be overridden to 1 to run the same stimulus against the single-rate stage. With both depths, the consecutive-capture stall and long random stalls on both streams exercise every skid occupancy, including push and pop in the same cycle.

// File: rtl/pin_streamer_pkg.sv
package pin_streamer_pkg;

    localparam int unsigned LAT_SDR = 1;
    localparam int unsigned LAT_DDR = 2;

    // bits needed to count 0..depth
    function automatic int unsigned cnt_bits(input int unsigned depth);
        int unsigned b;
        b = 1;
        while ((1 << b) <= depth) b++;
        return b;
    endfunction

endpackage

// File: rtl/pin_streamer_stage.sv
module pin_streamer_stage #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned META_W  = 6,
    parameter int unsigned LATENCY = pin_streamer_pkg::LAT_DDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WIDTH-1:0]  cmd_out,
    input  logic [WIDTH-1:0]  cmd_oe,
    input  logic              cmd_sample,
    input  logic [META_W-1:0] cmd_meta,
    input  logic [WIDTH-1:0]  pin_i,
    output logic [WIDTH-1:0]  pin_o,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              tail_flag,
    output logic [WIDTH-1:0]  tail_data,
    output logic [META_W-1:0] tail_meta
);

    typedef struct packed {
        logic [LATENCY-1:0][WIDTH-1:0]  drv;
        logic [LATENCY-1:0][WIDTH-1:0]  en;
        logic [LATENCY-1:0][WIDTH-1:0]  cap;
        logic [LATENCY-1:0]             want;
        logic [LATENCY-1:0][META_W-1:0] tag;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // first slot: drive values hold until the next command
        if (accept) begin
            st_d.drv[0] = cmd_out;
            st_d.en[0]  = cmd_oe;
        end
        // capture the pins as they stand at this edge
        st_d.cap[0]  = pin_i;
        st_d.want[0] = accept & cmd_sample;
        st_d.tag[0]  = cmd_meta;
        for (int k = 1; k < LATENCY; k++) begin
            st_d.drv[k]  = st_q.drv[k-1];
            st_d.en[k]   = st_q.en[k-1];
            st_d.cap[k]  = st_q.cap[k-1];
            st_d.want[k] = st_q.want[k-1];
            st_d.tag[k]  = st_q.tag[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o     = st_q.drv[LATENCY-1];
    assign pin_oe    = st_q.en[LATENCY-1];
    assign tail_flag = st_q.want[LATENCY-1];
    assign tail_data = st_q.cap[LATENCY-1];
    assign tail_meta = st_q.tag[LATENCY-1];

    // R2: pins show an accepted command exactly LATENCY edges later
    p_pins_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(accept, LATENCY) && $past(rst_n, LATENCY)) |->
        (pin_o == $past(cmd_out, LATENCY) && pin_oe == $past(cmd_oe, LATENCY)));

endmodule

// File: rtl/pin_streamer_skid.sv
module pin_streamer_skid #(
    parameter int unsigned ITEM_W = 10,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_flag,
    input  logic [ITEM_W-1:0] in_item,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ITEM_W-1:0] out_item,
    output logic              empty
);

    localparam int unsigned CW = pin_streamer_pkg::cnt_bits(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ITEM_W-1:0] ent;
        logic [CW-1:0]                cnt;
    } skid_t;

    skid_t sk_d, sk_q;
    logic  push, pop;
    logic [CW-1:0] mid;

    always_comb begin
        empty     = (sk_q.cnt == '0);
        out_valid = empty ? in_flag : 1'b1;
        out_item  = empty ? in_item : sk_q.ent[0];
        pop       = !empty && out_ready;
        // a fresh capture bypasses the store only if it leaves at once
        push      = in_flag && !(empty && out_ready);

        sk_d = sk_q;
        if (pop) begin
            for (int k = 0; k < DEPTH - 1; k++) sk_d.ent[k] = sk_q.ent[k+1];
        end
        mid = sk_q.cnt - CW'(pop);
        if (push && mid < CW'(DEPTH)) sk_d.ent[mid] = in_item;
        sk_d.cnt = mid + CW'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= '0;
        else        sk_q <= sk_d;
    end

    // R8: the store never has to take an entry it has no room for
    p_skid_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (sk_q.cnt < CW'(DEPTH)));

    // R6: an offered sample is held until taken
    p_hold_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_item)));

endmodule

// File: rtl/pin_streamer.sv
module pin_streamer #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned META_W  = 6,
    parameter int unsigned LATENCY = pin_streamer_pkg::LAT_DDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WIDTH-1:0]  cmd_out,
    input  logic [WIDTH-1:0]  cmd_oe,
    input  logic              cmd_sample,
    input  logic [META_W-1:0] cmd_meta,
    input  logic [WIDTH-1:0]  pin_i,
    output logic [WIDTH-1:0]  pin_o,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [WIDTH-1:0]  smp_data,
    output logic [META_W-1:0] smp_meta
);

    localparam int unsigned ITEM_W = WIDTH + META_W;

    logic              accept;
    logic              tail_flag;
    logic [WIDTH-1:0]  tail_data;
    logic [META_W-1:0] tail_meta;
    logic              skid_empty;
    logic [ITEM_W-1:0] head_item;

    // readiness ignores the capture bit; a busy store halts intake
    assign cmd_ready = smp_ready && skid_empty;
    assign accept    = cmd_valid && cmd_ready;

    pin_streamer_stage #(
        .WIDTH(WIDTH), .META_W(META_W), .LATENCY(LATENCY)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_sample(cmd_sample),
        .cmd_meta(cmd_meta), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .tail_flag(tail_flag), .tail_data(tail_data), .tail_meta(tail_meta)
    );

    pin_streamer_skid #(
        .ITEM_W(ITEM_W), .DEPTH(LATENCY)
    ) u_skid (
        .clk(clk), .rst_n(rst_n), .in_flag(tail_flag),
        .in_item({tail_data, tail_meta}), .out_ready(smp_ready),
        .out_valid(smp_valid), .out_item(head_item), .empty(skid_empty)
    );

    assign smp_data = head_item[ITEM_W-1:META_W];
    assign smp_meta = head_item[META_W-1:0];

    // R3: no command is taken while the consumer is stalled
    p_cmd_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> smp_ready);

endmodule

// File: tb/sim_pin_streamer.sv
`timescale 1ns/1ps
module sim_pin_streamer;
    parameter int unsigned LAT = 2;
    localparam int unsigned W  = 4;
    localparam int unsigned MW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, cmd_sample = 1'b0;
    logic [W-1:0] cmd_out = '0, cmd_oe = '0, pin_i = '0, pin_o, pin_oe, smp_data;
    logic [MW-1:0] cmd_meta = '0, smp_meta;
    logic smp_valid, smp_ready = 1'b1;

    always #2.5 clk = ~clk;

    pin_streamer #(.WIDTH(W), .META_W(MW), .LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_sample(cmd_sample),
        .cmd_meta(cmd_meta), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .smp_meta(smp_meta)
    );

    int n_chk = 0, n_bad = 0, wd = 0;
    logic mon_en = 1'b0;
    logic stall_cmd = 1'b0;
    logic [W+MW-1:0] sb[$];
    logic [W-1:0] exp_o[LAT], exp_oe[LAT];
    logic held = 1'b0;
    logic [W+MW-1:0] held_item;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int k = 0; k < LAT; k++) begin exp_o[k] = '0; exp_oe[k] = '0; end
    end

    // monitor: scoreboard pushes on accept, pops on delivery
    always @(negedge clk) begin
        if (mon_en) begin
            logic [W+MW-1:0] got, want;
            chk(pin_o == exp_o[LAT-1], "R2 pin_o", int'(pin_o), int'(exp_o[LAT-1]));
            chk(pin_oe == exp_oe[LAT-1], "R2 pin_oe", int'(pin_oe), int'(exp_oe[LAT-1]));
            if (cmd_ready && !smp_ready) chk(1'b0, "R3 ready gate", 1, 0);
            if (held) chk(smp_valid && {smp_data, smp_meta} == held_item,
                          "R6 hold", int'({smp_data, smp_meta}), int'(held_item));
            held      = smp_valid && !smp_ready;
            held_item = {smp_data, smp_meta};
            if (smp_valid && smp_ready) begin
                got = {smp_data, smp_meta};
                if (sb.size() == 0) chk(1'b0, "R1 unrequested sample", int'(got), 0);
                else begin
                    want = sb.pop_front();
                    chk(got == want, "R4 R7 sample data/meta", int'(got), int'(want));
                end
            end
            if (cmd_valid && cmd_ready && cmd_sample) sb.push_back({pin_i, cmd_meta});
            for (int k = LAT - 1; k > 0; k--) begin
                exp_o[k] = exp_o[k-1]; exp_oe[k] = exp_oe[k-1];
            end
            if (cmd_valid && cmd_ready) begin exp_o[0] = cmd_out; exp_oe[0] = cmd_oe; end
            stall_cmd = cmd_valid && !cmd_ready;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!smp_valid, "R9 smp_valid", int'(smp_valid), 0);
        chk(pin_o == '0 && pin_oe == '0, "R9 pins", int'({pin_o, pin_oe}), 0);
        chk(cmd_ready == smp_ready, "R9 cmd_ready", int'(cmd_ready), int'(smp_ready));

        // R1: drive-only command
        @(posedge clk); #1;
        cmd_valid = 1; cmd_sample = 0; cmd_out = 4'h9; cmd_oe = 4'hF; cmd_meta = 6'h3F;
        @(posedge clk); #1 cmd_valid = 0;
        repeat (LAT + 1) begin
            @(negedge clk);
            chk(!smp_valid, "R1 no sample", int'(smp_valid), 0);
        end

        // R5: on-time delivery with tag
        @(posedge clk); #1;
        cmd_valid = 1; cmd_sample = 1; cmd_meta = 6'h11; pin_i = 4'h6; cmd_out = 4'h1;
        @(posedge clk); #1 cmd_valid = 0; pin_i = 4'hB;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        chk(smp_valid && smp_meta == 6'h11 && smp_data == 4'h6, "R5 latency",
            int'({smp_valid, smp_data, smp_meta}), int'({1'b1, 4'h6, 6'h11}));
        repeat (4) @(posedge clk);

        // R7/R8: two captures back to back, then a one-cycle stall
        #1; cmd_valid = 1; cmd_sample = 1; cmd_meta = 6'h21; pin_i = 4'h3;
        @(posedge clk); #1; cmd_meta = 6'h22; pin_i = 4'hC;
        @(posedge clk); #1; cmd_valid = 0; smp_ready = 0; pin_i = 4'h0;
        @(posedge clk); #1; smp_ready = 1;
        @(negedge clk);
        chk(!cmd_ready, "R8 intake halted while store busy", int'(cmd_ready), 0);
        repeat (6) @(posedge clk);
        chk(sb.size() == 0, "R7 both delivered", sb.size(), 0);

        // random stalls on both streams
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            if (!stall_cmd) begin
                cmd_valid  = ($urandom % 4) != 0;
                cmd_sample = $urandom % 2;
                cmd_out    = W'($urandom);
                cmd_oe     = W'($urandom);
                cmd_meta   = MW'($urandom);
            end
            smp_ready = ((i / 500) % 2 == 1) ? (($urandom % 4) == 0) : (($urandom % 3) != 0);
            pin_i     = W'($urandom);
        end
        @(posedge clk); #1; cmd_valid = 0; smp_ready = 1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R7 nothing lost", sb.size(), 0);
        finish_run();
    end
endmodule